// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the slave side of a 512-byte serial nonvolatile memory. The storage is an on-chip byte array, and writes to it complete at once. A bus master drives chip select, the serial clock, serial data in and a pause input. The block returns read data through a data-out value and a separate output-enable, which together form a tri-state pin at the chip boundary. The serial clock is always an input, because the block can only act as a slave.

All pins are sampled with the block's own system clock, and the block acts on edges of the serial clock that it detects from those samples. The serial clock idles low. Input bits are taken on its rising edge and output bits change on its falling edge, most significant bit first in both directions. The first byte after select is an instruction. Six commands are decoded: set write enable, clear write enable, status read, status write, data read and data write. The two data commands carry the ninth address bit inside the instruction byte.

A transfer can be paused and resumed with the pause input, and it keeps its state while paused. An instruction byte that cannot be decoded locks the block out until the next select.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset, and while cs_n is high, so_oe is 0. Clocking sck and si while cs_n is high changes nothing.
- R2: The first byte after cs_n falls is the instruction, shifted in MSB first. Its bits [7:4] must be 0000. Bit 3 is a don't-care for the non-data commands.
- R3: Instruction 0000_x110 sets the write-enable flag. Status bit 1 reads as 1 afterwards.
- R4: Instruction 0000_x100 clears the write-enable flag.
- R5: Instruction 0000_x101 returns the status byte {4'b0, prot[1:0], wen, 1'b0} MSB first. It repeats that byte for as long as the master keeps clocking.
- R6: Instruction 0000_x001 followed by one byte stores bits [3:2] of that byte as prot[1:0], provided the write-enable flag is set.
- R7: Instruction 0000_A011 (A = address bit 8), followed by the byte A7..A0, returns memory data MSB first. Each bit is driven after a falling sck edge, and the first bit is valid before the rising edge that follows the last address bit.
- R8: A data read advances the 9-bit address after each byte and wraps from 511 to 0.
- R9: Instruction 0000_A010 plus an address byte stores each following byte at consecutive addresses, wrapping from 511 to 0. This happens only while the write-enable flag is set.
- R10: A data write or status write issued while the write-enable flag is clear changes no stored value.
- R11: When cs_n rises after a data or status write that was performed, the write-enable flag clears.
- R12: An instruction whose bits [7:4] are not 0000, or whose bits [2:0] are 000 or 111, causes every later bit to be ignored and keeps so_oe at 0 until cs_n goes high and low again. It leaves the write-enable flag unchanged.
- R13: hold_n driven low while sck is high pauses the transfer. During the pause so_oe is 0 and sck and si are ignored. hold_n driven high while sck is high resumes the transfer with no bit lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the master, idles low |
| si | input | 1 | Serial data from the master |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data value toward the master |
| so_oe | output | 1 | Drive enable for so; 0 means high impedance |

## Verification
The hardest condition to reach is a pause that starts in the middle of a read byte. The bench must lower hold_n while sck is high, clock sck several times with changing si, and raise hold_n while sck is high again. Only then can it show that the returned byte is unchanged and that the output was released during the pause. The bench builds this sequence bit by bit instead of through its byte task. The lockout case is also set up with care. The write-enable flag is set first, and an invalid instruction is sent that differs from a valid data write only in its upper nibble. Reading back the target address and the status then shows that the write was refused and the flag was kept.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W + 1;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_RDAT,
        ST_WDAT,
        ST_RSTAT,
        ST_WSTAT,
        ST_DONE,
        ST_LOCK
    } slv_state_e;

    typedef enum logic [2:0] {
        OP_WEN_SET,
        OP_WEN_CLR,
        OP_STAT_RD,
        OP_STAT_WR,
        OP_MEM_RD,
        OP_MEM_WR,
        OP_BAD
    } slv_op_e;

    typedef struct packed {
        slv_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-2:0]   sh;
        logic [BYTE_W-1:0]   out_sh;
        logic                so;
        logic                oe;
        logic [ADDR_W-1:0]   addr;
        logic                is_rd;
        logic                wen;
        logic                wr_done;
        logic [1:0]          prot;
    } slv_regs_t;

    // Upper nibble must be zero; bit 3 is ignored by the decode.
    function automatic slv_op_e op_decode(input logic [BYTE_W-1:0] b);
        if (b[7:4] != 4'b0000) return OP_BAD;
        case (b[2:0])
            3'b110:  return OP_WEN_SET;
            3'b100:  return OP_WEN_CLR;
            3'b101:  return OP_STAT_RD;
            3'b001:  return OP_STAT_WR;
            3'b011:  return OP_MEM_RD;
            3'b010:  return OP_MEM_WR;
            default: return OP_BAD;
        endcase
    endfunction

endpackage

// File: rtl/spi_ee_pins.sv
// Serial clock edge detection and pause tracking, gated by select and pause.
module spi_ee_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic rise_ev,
    output logic fall_ev,
    output logic hold_act
);

    typedef struct packed {
        logic sck;
        logic hold;
    } pin_regs_t;

    pin_regs_t p_d, p_q;

    always_comb begin
        p_d     = p_q;
        p_d.sck = sck;
        if (cs_n) begin
            p_d.hold = 1'b0;
        end else if (sck) begin
            // The pause only changes state while the serial clock is high.
            p_d.hold = ~hold_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rise_ev  = sck  & ~p_q.sck & ~cs_n & ~p_q.hold;
    assign fall_ev  = ~sck &  p_q.sck & ~cs_n & ~p_q.hold;
    assign hold_act = p_q.hold;

endmodule

// File: rtl/spi_ee_array.sv
// Byte storage: asynchronous read, single synchronous write port.
module spi_ee_array #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
    import spi_ee_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);

    localparam slv_regs_t REGS_RST = '{
        state:   ST_CMD,
        cnt:     '0,
        sh:      '0,
        out_sh:  '0,
        so:      1'b0,
        oe:      1'b0,
        addr:    '0,
        is_rd:   1'b0,
        wen:     1'b0,
        wr_done: 1'b0,
        prot:    2'b00
    };

    slv_regs_t r_d, r_q;

    logic              rise_ev, fall_ev, hold_act;
    logic [BYTE_W-1:0] byte_in;
    logic [BYTE_W-1:0] status;
    logic [ADDR_W-1:0] raddr;
    logic [BYTE_W-1:0] rdata;
    logic              mem_we;
    logic              wen, wr_done, locked;
    slv_op_e           op;

    spi_ee_pins u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .hold_n   (hold_n),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .hold_act (hold_act)
    );

    assign byte_in = {r_q.sh, si};
    assign status  = {4'b0000, r_q.prot, r_q.wen, 1'b0};
    assign op      = op_decode(byte_in);
    assign raddr   = (r_q.state == ST_ADDR) ? {r_q.addr[ADDR_W-1], byte_in}
                                            : r_q.addr + 1'b1;

    spi_ee_array #(
        .DATA_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (r_q.addr),
        .wdata (byte_in),
        .raddr (raddr),
        .rdata (rdata)
    );

    always_comb begin
        r_d    = r_q;
        mem_we = 1'b0;
        if (cs_n) begin
            r_d.state = ST_CMD;
            r_d.cnt   = '0;
            r_d.oe    = 1'b0;
            if (r_q.wr_done) begin
                r_d.wen     = 1'b0;
                r_d.wr_done = 1'b0;
            end
        end else begin
            if (hold_act) begin
                r_d.oe = 1'b0;
            end
            if (fall_ev && (r_q.state == ST_RDAT || r_q.state == ST_RSTAT)) begin
                r_d.so     = r_q.out_sh[BYTE_W-1];
                r_d.out_sh = {r_q.out_sh[BYTE_W-2:0], 1'b0};
                r_d.oe     = 1'b1;
            end
            if (rise_ev) begin
                r_d.sh  = byte_in[BYTE_W-2:0];
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(BYTE_W - 1)) begin
                    unique case (r_q.state)
                        ST_CMD: begin
                            unique case (op)
                                OP_WEN_SET: begin
                                    r_d.wen   = 1'b1;
                                    r_d.state = ST_DONE;
                                end
                                OP_WEN_CLR: begin
                                    r_d.wen   = 1'b0;
                                    r_d.state = ST_DONE;
                                end
                                OP_STAT_RD: begin
                                    r_d.out_sh = status;
                                    r_d.state  = ST_RSTAT;
                                end
                                OP_STAT_WR: r_d.state = ST_WSTAT;
                                OP_MEM_RD, OP_MEM_WR: begin
                                    r_d.addr[ADDR_W-1] = byte_in[3];
                                    r_d.is_rd          = (op == OP_MEM_RD);
                                    r_d.state          = ST_ADDR;
                                end
                                default: r_d.state = ST_LOCK;
                            endcase
                        end
                        ST_ADDR: begin
                            r_d.addr = {r_q.addr[ADDR_W-1], byte_in};
                            if (r_q.is_rd) begin
                                r_d.out_sh = rdata;
                                r_d.state  = ST_RDAT;
                            end else begin
                                r_d.state  = ST_WDAT;
                            end
                        end
                        ST_RDAT: begin
                            r_d.addr   = raddr;
                            r_d.out_sh = rdata;
                        end
                        ST_WDAT: begin
                            if (r_q.wen) begin
                                mem_we      = 1'b1;
                                r_d.wr_done = 1'b1;
                            end
                            r_d.addr = r_q.addr + 1'b1;
                        end
                        ST_RSTAT: r_d.out_sh = status;
                        ST_WSTAT: begin
                            if (r_q.wen) begin
                                r_d.prot    = byte_in[3:2];
                                r_d.wr_done = 1'b1;
                            end
                            r_d.state = ST_DONE;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign so      = r_q.so;
    assign so_oe   = r_q.oe;
    assign wen     = r_q.wen;
    assign wr_done = r_q.wr_done;
    assign locked  = (r_q.state == ST_LOCK);

endmodule

// File: rtl/spi_ee_slave_chk.sv
module spi_ee_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic so,
    input logic so_oe,
    input logic hold_act,
    input logic wen,
    input logic wr_done,
    input logic locked,
    input logic mem_we
);

    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe);

    assert_so_moves_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sck) |=> $stable(so));

    assert_write_needs_wen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wen);

    assert_wen_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && wr_done) |=> !wen);

    assert_lock_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !mem_we);

    assert_hold_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |=> !so_oe);

endmodule

bind spi_ee_slave spi_ee_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .so       (so),
    .so_oe    (so_oe),
    .hold_act (hold_act),
    .wen      (wen),
    .wr_done  (wr_done),
    .locked   (locked),
    .mem_we   (mem_we)
);

// File: tb/spi_ee_slave_tb_top.sv
module spi_ee_slave_tb_top;

    localparam int H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic hold_n = 1'b1;
    logic so, so_oe;

    int checks = 0;
    int fails  = 0;

    // {address[8:0], data[7:0]}
    localparam logic [16:0] VEC [8] = '{
        {9'h010, 8'h5A}, {9'h123, 8'hA5}, {9'h0FF, 8'hC3}, {9'h100, 8'h3C},
        {9'h1FE, 8'h81}, {9'h07F, 8'h7E}, {9'h180, 8'h00}, {9'h055, 8'hFF}
    };

    always #10 clk = ~clk;

    spi_ee_slave dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sck    (sck),
        .si     (si),
        .hold_n (hold_n),
        .so     (so),
        .so_oe  (so_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic bit_x(input logic b, output logic r, output logic e);
        si = b;
        tick(H);
        r = so;
        e = so_oe;
        sck = 1'b1;
        tick(H);
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output logic all_oe, output logic any_oe);
        logic r, e;
        all_oe = 1'b1;
        any_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_x(tx[i], r, e);
            rx[i]  = r;
            all_oe = all_oe & e;
            any_oe = any_oe | e;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic desel();
        tick(H);
        cs_n = 1'b1;
        tick(2 * H);
    endtask

    task automatic one_cmd(input logic [7:0] op);
        logic [7:0] rx;
        logic a, o;
        sel();
        xfer(op, rx, a, o);
        desel();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] rx;
        logic a, o;
        sel();
        xfer(8'h05, rx, a, o);
        xfer(8'h00, s, a, o);
        desel();
    endtask

    task automatic mem_wr(input logic [8:0] ad, input logic [7:0] d);
        logic [7:0] rx;
        logic a, o;
        sel();
        xfer({4'b0000, ad[8], 3'b010}, rx, a, o);
        xfer(ad[7:0], rx, a, o);
        xfer(d, rx, a, o);
        desel();
    endtask

    task automatic mem_rd(input logic [8:0] ad, output logic [7:0] d, output logic all_oe);
        logic [7:0] rx;
        logic a, o;
        sel();
        xfer({4'b0000, ad[8], 3'b011}, rx, a, o);
        xfer(ad[7:0], rx, a, o);
        xfer(8'h00, d, all_oe, o);
        desel();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] s, d, rx;
        logic a, o, r, e, any;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        tick(2);
        chk("R1 reset so_oe", {15'b0, so_oe}, 16'h0);
        chk("R1 reset so", {15'b0, so}, 16'h0);

        // R1: activity while deselected never enables the output
        any = 1'b0;
        for (int i = 0; i < 16; i++) begin
            bit_x(i[0], r, e);
            any = any | e | so_oe;
        end
        chk("R1 deselected activity", {15'b0, any}, 16'h0);

        // R2/R3: set write enable using bit 3 as don't-care, then read status
        one_cmd(8'h0E);
        rd_status(s);
        chk("R3 status after set", {8'h0, s}, 16'h0002);

        // R6/R11: status write stores protection bits, then enable clears
        sel();
        xfer(8'h01, rx, a, o);
        xfer(8'h0C, rx, a, o);
        desel();
        rd_status(s);
        chk("R6 R11 status after write", {8'h0, s}, 16'h000C);

        // R10: status write without enable is refused
        sel();
        xfer(8'h09, rx, a, o);
        xfer(8'h00, rx, a, o);
        desel();
        rd_status(s);
        chk("R10 status write refused", {8'h0, s}, 16'h000C);

        // R4: clear write enable
        one_cmd(8'h06);
        one_cmd(8'h04);
        rd_status(s);
        chk("R4 status after clear", {8'h0, s}, 16'h000C);

        // R5: repeated status bytes in one selection
        one_cmd(8'h06);
        sel();
        xfer(8'h05, rx, a, o);
        xfer(8'h00, s, a, o);
        chk("R5 status first", {8'h0, s}, 16'h000E);
        chk("R5 status output enabled", {15'b0, a}, 16'h1);
        xfer(8'h00, s, a, o);
        chk("R5 status repeat", {8'h0, s}, 16'h000E);
        desel();
        one_cmd(8'h04);

        // R7/R9: table of writes followed by readback
        for (int k = 0; k < 8; k++) begin
            one_cmd(8'h06);
            mem_wr(VEC[k][16:8], VEC[k][7:0]);
        end
        rd_status(s);
        chk("R11 enable cleared after data write", {8'h0, s}, 16'h000C);
        for (int k = 0; k < 8; k++) begin
            mem_rd(VEC[k][16:8], d, a);
            chk("R7 R9 readback", {8'h0, d}, {8'h0, VEC[k][7:0]});
            chk("R7 output enabled", {15'b0, a}, 16'h1);
        end

        // R8/R9: burst write and burst read across the top address
        one_cmd(8'h06);
        sel();
        xfer(8'h0A, rx, a, o);
        xfer(8'hFF, rx, a, o);
        xfer(8'hAA, rx, a, o);
        xfer(8'h55, rx, a, o);
        xfer(8'h3C, rx, a, o);
        desel();
        sel();
        xfer(8'h0B, rx, a, o);
        xfer(8'hFF, rx, a, o);
        xfer(8'h00, d, a, o);
        chk("R8 byte at 511", {8'h0, d}, 16'h00AA);
        xfer(8'h00, d, a, o);
        chk("R8 wrapped byte at 0", {8'h0, d}, 16'h0055);
        xfer(8'h00, d, a, o);
        chk("R8 byte at 1", {8'h0, d}, 16'h003C);
        desel();

        // R10: data write without enable
        mem_wr(9'h010, 8'hEE);
        mem_rd(9'h010, d, a);
        chk("R10 data write refused", {8'h0, d}, 16'h005A);

        // R12: invalid upper nibble locks out a would-be write
        one_cmd(8'h06);
        sel();
        xfer(8'h12, rx, a, o);
        any = o;
        xfer(8'h10, rx, a, o);
        any = any | o;
        xfer(8'hEE, rx, a, o);
        any = any | o;
        desel();
        chk("R12 output off in lockout", {15'b0, any}, 16'h0);
        mem_rd(9'h010, d, a);
        chk("R12 no write in lockout", {8'h0, d}, 16'h005A);
        rd_status(s);
        chk("R12 enable kept", {8'h0, s}, 16'h000E);

        // R12: low code 111 is invalid as well
        sel();
        xfer(8'h07, rx, a, o);
        any = o;
        xfer(8'h00, rx, a, o);
        any = any | o;
        xfer(8'h00, rx, a, o);
        any = any | o;
        desel();
        chk("R12 code 111 output off", {15'b0, any}, 16'h0);
        one_cmd(8'h04);

        // R13: pause in the middle of a read byte
        sel();
        xfer(8'h0B, rx, a, o);
        xfer(8'h23, rx, a, o);
        d = 8'h00;
        any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            if (i == 3) begin
                si = 1'b0;
                tick(H);
                d[i] = so;
                sck = 1'b1;
                tick(2);
                hold_n = 1'b0;
                tick(H);
                any = so_oe;
                repeat (3) begin
                    sck = 1'b0;
                    si = ~si;
                    tick(H);
                    any = any | so_oe;
                    sck = 1'b1;
                    tick(H);
                    any = any | so_oe;
                end
                hold_n = 1'b1;
                tick(2);
                sck = 1'b0;
            end else begin
                bit_x(1'b0, r, e);
                d[i] = r;
            end
        end
        desel();
        chk("R13 output off while paused", {15'b0, any}, 16'h0);
        chk("R13 byte intact across pause", {8'h0, d}, 16'h00A5);

        summary();
    end

endmodule